// File: doc/BRIEF.md
# Data-Edge Word Phase Aligner

This block sets the word boundary of a serializer when no word clock comes with the parallel data. It runs on the fast bit clock and keeps a divide-by-`WORD_BITS` word counter. The counter's phase is taken from the rising edges of one reference data bit (bit 0 of the parallel word). The skew between data bits is bounded well below one bit period, so one reference bit is enough. The reference bit and an active-low adjust request both pass through a flop synchronizer before any edge is detected.

Three events set the counter to zero on a synchronized rising edge of the reference bit. The first is the first edge after reset. The second is an edge that lands too far from the aligned point; distance is measured as the circular distance of the counter value from zero. The third is an edge seen while the adjust request is held low, and this forced alignment is honoured once per reset. Every alignment starts a monitor pulse of fixed delay and length, and a longer flag that marks the following serial bits as invalid. The block does nothing unless the mode input selects clockless transfer. While it is idle, the counter holds its value.

Top module: `word_phase_aligner`

## Requirements
- R1: While rst_n is low, word_phase is 0, load_strobe is 0, mon_pulse is 0 and bits_invalid is 0.
- R2: While clockless_mode is 1 and no alignment occurs, word_phase advances by one per clock modulo WORD_BITS (16). load_strobe is 1 exactly in the cycle where word_phase is 15.
- R3: Number the clock edges from the first edge that samples data_bit0 at 1 after it was 0. The first such rising transition after reset makes word_phase read 0 after edge 3. Falling transitions have no effect.
- R4: A later rising transition aligns again (word_phase 0 after edge 3) only when the counter value it was detected against is more than 6 away from 0 in either direction modulo 16. This value equals word_phase after the edge before the transition plus 2. At a distance of 6 or less the counter keeps counting and no monitor pulse is produced.
- R5: A rising transition detected while adj_req_n is low forces an alignment whatever the distance. This is honoured once only. A further forced alignment needs a reset.
- R6: After an alignment, mon_pulse is 1 after edges 5 through 16 (12 cycles), counted as in R3, and 0 otherwise.
- R7: bits_invalid rises together with mon_pulse and stays 1 for 16 cycles (after edges 5 through 20).
- R8: While clockless_mode is 0, word_phase holds its value, rising transitions of data_bit0 cause no alignment, and mon_pulse stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset; also re-arms the forced alignment |
| clockless_mode | input | 1 | 1 selects clockless transfer and enables the aligner |
| adj_req_n | input | 1 | Active-low forced-alignment request (asynchronous) |
| data_bit0 | input | 1 | Reference data bit (asynchronous) |
| word_phase | output | $clog2(WORD_BITS) | Current word counter value |
| load_strobe | output | 1 | Word-load strobe, high in the last bit slot of each word |
| mon_pulse | output | 1 | Monitor pulse for each alignment |
| bits_invalid | output | 1 | Serial bits after an alignment are invalid |

## Verification
The drift threshold is probed on both sides and in both directions: offsets of 6 ahead and 6 behind must leave the counter alone, and offsets of 7 and 9 must realign it. A design using a one-sided or off-by-one compare would realign at the boundary or miss one direction. The forced request is applied twice in one reset interval and once more after a reset. A design that never disarms would realign on the second request, and one that never re-arms would ignore the third. The monitor and invalid windows are checked at their first and last high cycles and at their first low cycle, and an idle mode with a live reference edge must leave the counter frozen and the monitor quiet.

// File: rtl/wpa_pkg.sv
`timescale 1ns/1ps
package wpa_pkg;
   // circular distance of a counter value from zero on a ring of size modulus
   function automatic int ring_distance(input int value, input int modulus);
      int v;
      v = value % modulus;
      return (v > modulus / 2) ? (modulus - v) : v;
   endfunction
endpackage

// File: rtl/wpa_sync.sv
`timescale 1ns/1ps
module wpa_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 1,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam int CHAIN_W = STAGES * WIDTH;

   logic [CHAIN_W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[CHAIN_W-WIDTH-1:0], d};
   end

   assign q = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/wpa_word_counter.sv
`timescale 1ns/1ps
module wpa_word_counter #(
   parameter int WORD_BITS = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         enable,
   input  logic                         realign,
   output logic [$clog2(WORD_BITS)-1:0] phase,
   output logic                         load_strobe
);
   localparam int CW = $clog2(WORD_BITS);
   localparam logic [CW-1:0] LAST = CW'(WORD_BITS - 1);
   localparam bit POW2 = ((1 << CW) == WORD_BITS);

   logic [CW-1:0] next_phase;

   generate
      if (POW2) begin : g_wrap_free
         assign next_phase = phase + CW'(1);
      end else begin : g_wrap_cmp
         assign next_phase = (phase == LAST) ? '0 : phase + CW'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       phase <= '0;
      else if (enable) begin
         if (realign)   phase <= '0;
         else           phase <= next_phase;
      end
   end

   assign load_strobe = rst_n && (phase == LAST);
endmodule

// File: rtl/wpa_align_ctrl.sv
`timescale 1ns/1ps
module wpa_align_ctrl
   import wpa_pkg::*;
#(
   parameter int WORD_BITS   = 16,
   parameter int DRIFT_LIMIT = 6
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         enable,
   input  logic                         ref_sync,
   input  logic                         req_n_sync,
   input  logic [$clog2(WORD_BITS)-1:0] phase,
   output logic                         align_evt,
   output logic                         force_evt
);
   logic ref_prev;
   logic have_ref;
   logic armed;
   logic ref_rise;
   logic drifted;

   assign ref_rise  = enable && ref_sync && !ref_prev;
   assign drifted   = have_ref && (ring_distance(int'(phase), WORD_BITS) > DRIFT_LIMIT);
   assign force_evt = ref_rise && armed && !req_n_sync;
   assign align_evt = ref_rise && (force_evt || !have_ref || drifted);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_prev <= 1'b0;
         have_ref <= 1'b0;
         armed    <= 1'b1;
      end else begin
         ref_prev <= ref_sync;
         if (align_evt) have_ref <= 1'b1;
         if (force_evt) armed    <= 1'b0;
      end
   end
endmodule

// File: rtl/wpa_monitor.sv
`timescale 1ns/1ps
module wpa_monitor #(
   parameter int MON_DELAY    = 3,
   parameter int MON_WIDTH    = 12,
   parameter int INVALID_BITS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic trigger,
   output logic mon_pulse,
   output logic bits_invalid
);
   localparam int SPAN = (MON_WIDTH > INVALID_BITS) ? MON_WIDTH : INVALID_BITS;
   localparam int LAST = MON_DELAY + SPAN - 1;
   localparam int TW   = $clog2(LAST + 1);

   logic [TW-1:0] timer;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 timer <= '0;
      else if (!enable)           timer <= '0;
      else if (trigger)           timer <= TW'(1);
      else if (timer != '0)       timer <= (int'(timer) == LAST) ? '0 : timer + TW'(1);
   end

   assign mon_pulse    = (int'(timer) >= MON_DELAY) && (int'(timer) < MON_DELAY + MON_WIDTH);
   assign bits_invalid = (int'(timer) >= MON_DELAY) && (int'(timer) < MON_DELAY + INVALID_BITS);
endmodule

// File: rtl/word_phase_aligner.sv
`timescale 1ns/1ps
module word_phase_aligner #(
   parameter int WORD_BITS    = 16,
   parameter int SYNC_STAGES  = 2,
   parameter int DRIFT_LIMIT  = 6,
   parameter int MON_DELAY    = 3,
   parameter int MON_WIDTH    = 12,
   parameter int INVALID_BITS = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clockless_mode,
   input  logic                         adj_req_n,
   input  logic                         data_bit0,
   output logic [$clog2(WORD_BITS)-1:0] word_phase,
   output logic                         load_strobe,
   output logic                         mon_pulse,
   output logic                         bits_invalid
);
   localparam int CW = $clog2(WORD_BITS);

   generate
      if (WORD_BITS < 4) begin : g_bad_word
         $error("WORD_BITS must be at least 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (DRIFT_LIMIT < 1 || DRIFT_LIMIT >= WORD_BITS / 2) begin : g_bad_drift
         $error("DRIFT_LIMIT must lie between 1 and WORD_BITS/2-1");
      end
      if (MON_DELAY < 1 || MON_WIDTH < 1 || INVALID_BITS < 1) begin : g_bad_mon
         $error("monitor timing parameters must be positive");
      end
   endgenerate

   logic [1:0] raw_in;
   logic [1:0] sync_out;
   logic       ref_sync;
   logic       req_n_sync;
   logic       align_evt;
   logic       force_evt;

   assign raw_in = {adj_req_n, data_bit0};

   wpa_sync #(
      .STAGES   (SYNC_STAGES),
      .WIDTH    (2),
      .RESET_VAL(2'b10)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw_in),
      .q    (sync_out)
   );

   assign req_n_sync = sync_out[1];
   assign ref_sync   = sync_out[0];

   wpa_align_ctrl #(
      .WORD_BITS  (WORD_BITS),
      .DRIFT_LIMIT(DRIFT_LIMIT)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (clockless_mode),
      .ref_sync  (ref_sync),
      .req_n_sync(req_n_sync),
      .phase     (word_phase),
      .align_evt (align_evt),
      .force_evt (force_evt)
   );

   wpa_word_counter #(
      .WORD_BITS(WORD_BITS)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (clockless_mode),
      .realign    (align_evt),
      .phase      (word_phase),
      .load_strobe(load_strobe)
   );

   wpa_monitor #(
      .MON_DELAY   (MON_DELAY),
      .MON_WIDTH   (MON_WIDTH),
      .INVALID_BITS(INVALID_BITS)
   ) u_mon (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable      (clockless_mode),
      .trigger     (align_evt),
      .mon_pulse   (mon_pulse),
      .bits_invalid(bits_invalid)
   );

   logic [CW-1:0] unused_cw;
   assign unused_cw = '0;
endmodule

// File: rtl/wpa_checker.sv
`timescale 1ns/1ps
module wpa_checker #(
   parameter int WORD_BITS = 16,
   parameter int MON_WIDTH = 12
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         clockless_mode,
   input logic [$clog2(WORD_BITS)-1:0] word_phase,
   input logic                         mon_pulse,
   input logic                         bits_invalid,
   input logic                         align_evt,
   input logic                         force_evt
);
   logic [7:0] forces_seen;
   logic [7:0] mon_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         forces_seen <= '0;
         mon_run     <= '0;
      end else begin
         if (force_evt && forces_seen != 8'hFF) forces_seen <= forces_seen + 8'd1;
         mon_run <= mon_pulse ? mon_run + 8'd1 : 8'd0;
      end
   end

   // R1
   a_r1_reset_clears: assert property (@(posedge clk)
      !rst_n |=> (word_phase == '0 && !mon_pulse && !bits_invalid));

   // R2
   a_r2_counts_up: assert property (@(posedge clk) disable iff (!rst_n)
      (clockless_mode && !align_evt) |=>
         int'(word_phase) == (int'($past(word_phase)) + 1) % WORD_BITS);

   // R3
   a_r3_align_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
      align_evt |=> word_phase == '0);

   // R5
   a_r5_single_force: assert property (@(posedge clk) disable iff (!rst_n)
      force_evt |-> forces_seen == 8'd0);

   // R6
   a_r6_mon_after_align: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mon_pulse) |-> $past(align_evt, 3));

   // R6
   a_r6_mon_length: assert property (@(posedge clk) disable iff (!rst_n)
      mon_pulse |-> int'(mon_run) < MON_WIDTH);

   // R7
   a_r7_invalid_covers_mon: assert property (@(posedge clk) disable iff (!rst_n)
      mon_pulse |-> bits_invalid);

   // R8
   a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !clockless_mode |=> word_phase == $past(word_phase));

   // R8
   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !clockless_mode |-> !align_evt);
endmodule

bind word_phase_aligner wpa_checker #(
   .WORD_BITS(WORD_BITS),
   .MON_WIDTH(MON_WIDTH)
) u_wpa_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .clockless_mode(clockless_mode),
   .word_phase    (word_phase),
   .mon_pulse     (mon_pulse),
   .bits_invalid  (bits_invalid),
   .align_evt     (align_evt),
   .force_evt     (force_evt)
);

// File: tb/word_phase_aligner_test.sv
`timescale 1ns/1ps
module word_phase_aligner_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clockless_mode = 1'b1;
   logic       adj_req_n = 1'b1;
   logic       data_bit0 = 1'b0;
   logic [3:0] word_phase;
   logic       load_strobe;
   logic       mon_pulse;
   logic       bits_invalid;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   word_phase_aligner uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .clockless_mode(clockless_mode),
      .adj_req_n     (adj_req_n),
      .data_bit0     (data_bit0),
      .word_phase    (word_phase),
      .load_strobe   (load_strobe),
      .mon_pulse     (mon_pulse),
      .bits_invalid  (bits_invalid)
   );

   task automatic chk(input string what, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wait_phase(input int v);
      for (int i = 0; i < 40 && int'(word_phase) != v; i++) step(1);
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst_n = 1'b0;
      data_bit0 = 1'b0;
      adj_req_n = 1'b1;
      clockless_mode = 1'b1;
      step(3);
      rst_n = 1'b1;
      step(1);
   endtask

   // one rising edge on the reference bit, started when word_phase==start
   task automatic probe(input int start, input bit aligns, input string req);
      wait_phase(start);
      data_bit0 = 1'b1;
      step(3);
      chk({req, " phase after edge"}, word_phase, aligns ? 0 : (start + 3) % 16);
      data_bit0 = 1'b0;
      step(2);
      chk({req, " monitor"}, mon_pulse, aligns);
      chk({req, " invalid"}, bits_invalid, aligns);
      step(20);
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b0;
      step(2);
      chk("R1 phase", word_phase, 0);
      chk("R1 strobe", load_strobe, 0);
      chk("R1 monitor", mon_pulse, 0);
      chk("R1 invalid", bits_invalid, 0);
      rst_n = 1'b1;
      step(1);
   endtask

   task automatic t_count();
      int p;
      p = int'(word_phase);
      step(1);
      chk("R2 increment", word_phase, (p + 1) % 16);
      wait_phase(15);
      chk("R2 strobe at 15", load_strobe, 1);
      step(1);
      chk("R2 wrap", word_phase, 0);
      chk("R2 strobe off", load_strobe, 0);
   endtask

   task automatic t_first_align();
      wait_phase(5);
      data_bit0 = 1'b1;
      step(3);
      chk("R3 first edge aligns", word_phase, 0);
      chk("R6 monitor not yet", mon_pulse, 0);
      data_bit0 = 1'b0;
      step(1);
      chk("R6 monitor still low", mon_pulse, 0);
      step(1);
      chk("R6 monitor first high", mon_pulse, 1);
      chk("R7 invalid first high", bits_invalid, 1);
      step(11);
      chk("R6 monitor last high", mon_pulse, 1);
      step(1);
      chk("R6 monitor ends", mon_pulse, 0);
      chk("R7 invalid continues", bits_invalid, 1);
      step(3);
      chk("R7 invalid last high", bits_invalid, 1);
      step(1);
      chk("R7 invalid ends", bits_invalid, 0);
      step(10);
   endtask

   task automatic t_drift();
      probe(4, 1'b0, "R4 ahead by 6");
      probe(5, 1'b1, "R4 ahead by 7");
      probe(8, 1'b0, "R4 behind by 6");
      probe(7, 1'b1, "R4 behind by 7");
      probe(14, 1'b0, "R4 in phase");
   endtask

   task automatic t_force();
      adj_req_n = 1'b0;
      step(4);
      probe(1, 1'b1, "R5 forced near edge");
      probe(1, 1'b0, "R5 second force ignored");
      adj_req_n = 1'b1;
      apply_reset();
      probe(3, 1'b1, "R3 first edge after reset");
      adj_req_n = 1'b0;
      step(4);
      probe(1, 1'b1, "R5 re-armed by reset");
      adj_req_n = 1'b1;
      step(4);
   endtask

   task automatic t_idle();
      int p;
      clockless_mode = 1'b0;
      step(1);
      p = int'(word_phase);
      step(5);
      chk("R8 phase held", word_phase, p);
      data_bit0 = 1'b1;
      step(6);
      chk("R8 edge ignored", word_phase, p);
      chk("R8 no monitor", mon_pulse, 0);
      clockless_mode = 1'b1;
      step(1);
      chk("R8 resumes counting", word_phase, (p + 1) % 16);
      data_bit0 = 1'b0;
      step(2);
      chk("R8 no late monitor", mon_pulse, 0);
   endtask

   initial begin
      apply_reset();
      t_reset();
      t_count();
      t_first_align();
      t_drift();
      t_force();
      t_idle();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!done) begin
         done = 1'b1;
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule